// File: doc/BRIEF.md
# Protection Region Bound Decoder

This block keeps a small table of memory protection entries and turns each one into an inclusive byte range of the physical address space. Each entry holds a matching mode and a raw address word. The raw word stores physical address bits [PA_W-1:2]. Software fills the table through an indexed write port. One flag picks whether a write goes to an entry's configuration byte or to its address word.

For every entry the block drives a registered lower bound, a registered upper bound and an enable flag. It also drives a registered count of the entries whose mode is not off. An access checker placed downstream can compare request addresses against these bounds without decoding anything itself.

There are four modes. A disabled entry covers nothing. A top-of-range entry starts where the previous entry's address word points. A four-byte entry covers one aligned word. A power-of-two entry takes its size from the number of trailing ones in its address word. Every entry is decoded again on every cycle, so a change to one entry's address word also updates the next entry's top-of-range lower bound.

Top module: `pmp_region_decoder`

## Requirements
- R1: After reset every configuration is off and every address word is 0. Every enable flag, every bound and the active count read 0.
- R2: A configuration write (wr_sel_addr=0) takes the mode from wr_data[4:3]: 0 off, 1 top-of-range, 2 four-byte, 3 power-of-two. The other data bits have no effect on any output.
- R3: An entry in off mode drives enable 0 and both bounds 0.
- R4: A top-of-range entry i has a lower bound of P<<2, where P is the address word of entry i-1, or 0 for entry 0. Its upper bound is (A<<2)-1 and its enable is 1, provided A>P. If A<=P the region is empty: enable 0 and both bounds 0.
- R5: A four-byte entry has a lower bound of A<<2, an upper bound of (A<<2)+3, and enable 1.
- R6: A power-of-two entry whose address word has t trailing ones, with t below the word width, spans 2^(t+3) bytes. Its lower bound is A with its low t bits cleared, shifted left by 2. Its enable is 1.
- R7: A power-of-two entry whose address word is all ones spans 0 up to the all-ones physical address.
- R8: Writing the address word of entry i changes the top-of-range bounds of entry i+1 without any write to entry i+1.
- R9: The active count equals the number of entries whose mode is not off. This includes empty top-of-range entries.
- R10: A write is captured at one clock edge and the outputs change at the following edge. Until then the outputs keep their earlier values. With no writes the outputs hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel_addr | input | 1 | 1 writes the address word, 0 writes the configuration byte |
| wr_idx | input | $clog2(NUM_ENT) | Entry index of the write |
| wr_data | input | PA_W-2 | Write data; a configuration write uses bits [7:0] |
| rgn_lo | output | NUM_ENT*PA_W | Lower bounds; entry i occupies bits [i*PA_W +: PA_W] |
| rgn_hi | output | NUM_ENT*PA_W | Upper bounds, laid out like rgn_lo |
| rgn_en | output | NUM_ENT | Per-entry flag marking a non-empty region |
| active_cnt | output | $clog2(NUM_ENT+1) | Number of entries not in off mode |

## Verification
The random part writes mixed configuration bytes and address words to random entries and compares every entry's bounds with a bench model after each write.

The directed cases each target one distinction:
- Power-of-two words with 0 trailing ones, 31 trailing ones and all ones check that the size comes from the trailing ones and that the full-span case is handled.
- Top-of-range entries at index 0, chained after one another, and with an upper word at or below the lower word check the lower-bound source and the empty case.
- Configuration bytes with every non-mode bit set show that only bits 4:3 matter.
- Changing a lower neighbour's address word checks that the dependent entry is decoded again.

// File: rtl/pmp_region_decoder.sv
module pmp_region_decoder #(
  parameter int NUM_ENT = 8,
  parameter int PA_W = 34,
  localparam int RAW_W = PA_W - 2,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int CNT_W = $clog2(NUM_ENT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_sel_addr,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [RAW_W-1:0]         wr_data,
  output logic [NUM_ENT*PA_W-1:0]  rgn_lo,
  output logic [NUM_ENT*PA_W-1:0]  rgn_hi,
  output logic [NUM_ENT-1:0]       rgn_en,
  output logic [CNT_W-1:0]         active_cnt
);

  localparam logic [1:0] MD_OFF   = 2'd0;
  localparam logic [1:0] MD_TOR   = 2'd1;
  localparam logic [1:0] MD_NA4   = 2'd2;
  localparam logic [1:0] MD_NAPOT = 2'd3;

  logic [1:0]       mode_q [NUM_ENT];
  logic [RAW_W-1:0] raw_q  [NUM_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_ENT; k++) begin
        mode_q[k] <= MD_OFF;
        raw_q[k]  <= '0;
      end
    end else if (wr_en && (int'(wr_idx) < NUM_ENT)) begin
      if (wr_sel_addr) raw_q[wr_idx]  <= wr_data;
      else             mode_q[wr_idx] <= wr_data[4:3];
    end
  end

  logic [PA_W-1:0] lo_d [NUM_ENT];
  logic [PA_W-1:0] hi_d [NUM_ENT];
  logic [NUM_ENT-1:0] en_d;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic [RAW_W-1:0] prev_raw;
    logic [RAW_W-1:0] ones_mask;
    logic [PA_W-1:0]  base_pa;

    if (i == 0) begin : g_first
      assign prev_raw = '0;
    end else begin : g_rest
      assign prev_raw = raw_q[i-1];
    end

    assign ones_mask = raw_q[i] ^ (raw_q[i] + RAW_W'(1));
    assign base_pa   = {raw_q[i], 2'b00};

    always_comb begin
      lo_d[i] = '0;
      hi_d[i] = '0;
      en_d[i] = 1'b0;
      unique case (mode_q[i])
        MD_TOR: if (raw_q[i] > prev_raw) begin
          lo_d[i] = {prev_raw, 2'b00};
          hi_d[i] = base_pa - PA_W'(1);
          en_d[i] = 1'b1;
        end
        MD_NA4: begin
          lo_d[i] = base_pa;
          hi_d[i] = base_pa + PA_W'(3);
          en_d[i] = 1'b1;
        end
        MD_NAPOT: begin
          lo_d[i] = {raw_q[i] & ~ones_mask, 2'b00};
          hi_d[i] = base_pa | {ones_mask, 2'b11};
          en_d[i] = 1'b1;
        end
        default: ;
      endcase
    end
  end

  logic [CNT_W-1:0] cnt_d;
  always_comb begin
    cnt_d = '0;
    for (int k = 0; k < NUM_ENT; k++)
      cnt_d = cnt_d + CNT_W'(mode_q[k] != MD_OFF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgn_lo     <= '0;
      rgn_hi     <= '0;
      rgn_en     <= '0;
      active_cnt <= '0;
    end else begin
      for (int k = 0; k < NUM_ENT; k++) begin
        rgn_lo[k*PA_W +: PA_W] <= lo_d[k];
        rgn_hi[k*PA_W +: PA_W] <= hi_d[k];
      end
      rgn_en     <= en_d;
      active_cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/pmp_region_decoder_chk.sv
module pmp_region_decoder_chk #(
  parameter int NUM_ENT = 8,
  parameter int PA_W = 34,
  localparam int RAW_W = PA_W - 2,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
  localparam int CNT_W = $clog2(NUM_ENT + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     wr_sel_addr,
  input logic [IDX_W-1:0]         wr_idx,
  input logic [RAW_W-1:0]         wr_data,
  input logic [NUM_ENT*PA_W-1:0]  rgn_lo,
  input logic [NUM_ENT*PA_W-1:0]  rgn_hi,
  input logic [NUM_ENT-1:0]       rgn_en,
  input logic [CNT_W-1:0]         active_cnt
);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rgn_en == '0 && active_cnt == '0 && rgn_lo == '0 && rgn_hi == '0)); // R1

  AST_CNT_COVERS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgn_en) <= int'(active_cnt)); // R9

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !$past(wr_en)) |=> ($stable(rgn_lo) && $stable(rgn_hi) && $stable(rgn_en) && $stable(active_cnt))); // R10

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_chk
    AST_BOUND_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_en[i] |-> (rgn_lo[i*PA_W +: PA_W] <= rgn_hi[i*PA_W +: PA_W])); // R4
    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rgn_en[i] |-> (rgn_lo[i*PA_W +: PA_W] == '0 && rgn_hi[i*PA_W +: PA_W] == '0)); // R3
  end

endmodule

bind pmp_region_decoder pmp_region_decoder_chk #(.NUM_ENT(NUM_ENT), .PA_W(PA_W)) u_chk (.*);

// File: tb/pmp_region_decoder_tb.sv
module pmp_region_decoder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int PW = 34;
  localparam int RW = PW - 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_sel_addr = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [RW-1:0] wr_data = '0;
  logic [NE*PW-1:0] rgn_lo, rgn_hi;
  logic [NE-1:0] rgn_en;
  logic [3:0] active_cnt;

  int checks = 0;
  int errors = 0;
  logic [1:0]    m_mode [NE];
  logic [RW-1:0] m_raw  [NE];

  always #(CLK_PERIOD/2) clk = ~clk;

  pmp_region_decoder #(.NUM_ENT(NE), .PA_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel_addr(wr_sel_addr),
    .wr_idx(wr_idx), .wr_data(wr_data), .rgn_lo(rgn_lo), .rgn_hi(rgn_hi),
    .rgn_en(rgn_en), .active_cnt(active_cnt));

  task automatic expect_ent(input int i, output logic [PW-1:0] lo,
                            output logic [PW-1:0] hi, output logic en);
    logic [63:0] raw, prev, base, top;
    int t;
    raw = 64'(m_raw[i]);
    prev = (i == 0) ? 64'd0 : 64'(m_raw[i-1]);
    lo = '0; hi = '0; en = 1'b0;
    case (m_mode[i])
      2'd1: if (raw > prev) begin
        lo = PW'(prev << 2); hi = PW'((raw << 2) - 64'd1); en = 1'b1;
      end
      2'd2: begin lo = PW'(raw << 2); hi = PW'((raw << 2) + 64'd3); en = 1'b1; end
      2'd3: begin
        t = 0;
        while (t < RW && raw[t]) t++;
        en = 1'b1;
        if (t == RW) begin lo = '0; hi = '1; end
        else begin
          base = ((raw >> t) << t) << 2;
          top = base + (64'd1 << (t + 3)) - 64'd1;
          lo = PW'(base); hi = PW'(top);
        end
      end
      default: ;
    endcase
  endtask

  function automatic string tag_of(input int i);
    case (m_mode[i])
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return (m_raw[i] == '1) ? "R7" : "R6";
    endcase
  endfunction

  task automatic check_all(input string why);
    logic [PW-1:0] elo, ehi; logic een; int cnt;
    cnt = 0;
    for (int i = 0; i < NE; i++) begin
      expect_ent(i, elo, ehi, een);
      if (m_mode[i] != 2'd0) cnt++;
      checks++;
      if (rgn_lo[i*PW +: PW] !== elo || rgn_hi[i*PW +: PW] !== ehi || rgn_en[i] !== een) begin
        errors++;
        $display("FAIL %s/%s entry %0d lo %h hi %h en %b expected lo %h hi %h en %b",
                 why, tag_of(i), i, rgn_lo[i*PW +: PW], rgn_hi[i*PW +: PW], rgn_en[i], elo, ehi, een);
      end
    end
    checks++;
    if (int'(active_cnt) != cnt) begin
      errors++;
      $display("FAIL %s/R9 active_cnt %0d expected %0d", why, active_cnt, cnt);
    end
  endtask

  task automatic wr(input bit sel, input int idx, input logic [RW-1:0] d, input string why);
    @(negedge clk);
    wr_en = 1'b1; wr_sel_addr = sel; wr_idx = 3'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    check_all("R10 before update");
    if (sel) m_raw[idx] = d; else m_mode[idx] = d[4:3];
    @(negedge clk);
    check_all(why);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < NE; i++) begin m_mode[i] = 2'd0; m_raw[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    wr(1, 0, 32'h0000_1000, "R5 addr");
    wr(0, 0, 32'h0000_0010, "R5 na4");
    wr(0, 0, 32'h0000_00E7, "R2 non-mode bits");
    wr(0, 0, 32'h0000_00FF, "R2 napot via ff");
    wr(1, 0, 32'h0000_1002, "R6 t0");
    wr(1, 0, 32'h7FFF_FFFF, "R6 t31");
    wr(1, 0, 32'hFFFF_FFFF, "R7 all ones");
    wr(1, 0, 32'h0000_0100, "R4 prep");
    wr(0, 0, 32'h0000_0008, "R4 entry0 tor");
    wr(1, 1, 32'h0000_0300, "R4 chain addr");
    wr(0, 1, 32'h0000_0008, "R4 chain tor");
    wr(1, 0, 32'h0000_0200, "R8 neighbour update");
    wr(1, 0, 32'h0000_0300, "R4 empty equal");
    wr(1, 0, 32'h0000_0400, "R4 empty below");
    wr(0, 2, 32'h0000_0008, "R9 empty tor counted");
    wr(0, 1, 32'h0000_0000, "R3 off again");

    for (int n = 0; n < 400; n++) begin
      logic [RW-1:0] d;
      int sh;
      d = RW'($urandom);
      if (($urandom % 4) == 0) begin
        sh = int'($urandom % RW);
        d = (d << sh) | ((RW'(1) << sh) - RW'(1));
      end
      wr(($urandom % 2) == 1, int'($urandom % NE), d, "random R8");
    end

    repeat (3) @(negedge clk);
    check_all("R10 idle hold");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule